// File: doc/BRIEF.md
# Indirect Table Access Port

This block gives a host bus a narrow window onto a 1024-entry table memory whose entries are 64 bits wide. The host reaches the table through five consecutive 16-bit control words. One word holds the table pointer and a post-increment switch. Four data words carry the slices of one entry. The slice at the lowest address is the least significant.

To fill the table, the host loads the pointer word. It writes the three lower slices in any order, then writes the top slice. That final write stores all four slices into the addressed entry. When the switch is on, it also moves the pointer forward.

Reading is symmetrical. Loading the pointer word fetches the addressed entry into a set of read copies. The host may read the lower slices in any order. Reading the top slice ends the access. With the switch on, that read moves the pointer and fetches the next entry. Every pointer change, and every commit, refills the read copies.

Top module: `tblwin_top`

## Requirements
- R1: After reset the pointer word reads 0 and the data words at 0x14 to 0x16 read 0.
- R2: The pointer word sits at 0x13. Its bits 9:0 hold the table pointer, its bit 15 holds the post-increment switch, and its other bits read 0.
- R3: A write to 0x13 loads the pointer from bits 9:0 and the switch from bit 15, and fetches the addressed entry.
- R4: Writes to 0x14, 0x15 and 0x16 stage slices 0, 1 and 2. A write to 0x17 stores {0x17 data, slice 2, slice 1, slice 0} into the entry at the current pointer.
- R5: A write to 0x17 with the switch on advances the pointer by one.
- R6: With the switch off, neither a write nor a read of 0x17 moves the pointer.
- R7: Reads of 0x14 to 0x17 return slices 0 to 3 of the fetched entry. Reads of 0x14 to 0x16 leave the pointer alone.
- R8: A read of 0x17 with the switch on advances the pointer and fetches the next entry.
- R9: The fetched entry appears in the read copies on the second clock edge after the edge that accepted the triggering access.
- R10: The pointer wraps from 1023 to 0.
- R11: A commit in the cycle when a fetch is due takes the memory port first. The fetch then runs in a later cycle, so the read copies end up holding the entry at the final pointer.
- R12: Addresses outside 0x13 to 0x17 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access; ignored while hst_wr is high |
| hst_addr | input | 6 | Host word address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Read data for hst_addr |

## Verification
The single-port memory can be asked to do two things in the same cycle: store a committed entry, and fetch the entry that the previous commit or pointer load requested. The bench provokes this by writing 0x17 on two consecutive cycles with post-increment on, starting at entry 1022. The second commit therefore lands while the first commit's fetch is pending, and the pointer wraps to 0 at the same time. The outcome is judged three ways: by the pointer word, by the read copies that settle on entry 0, and by reading entries 1022 and 1023 back. A bench model that advances every clock checks the read data the whole time.

// File: rtl/tblwin_pkg.sv
package tblwin_pkg;

  // One decoded host access per cycle; a write wins over a read.
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SET,      // write of the pointer word
    ACC_STAGE,    // write of a lower slice
    ACC_COMMIT,   // write of the top slice
    ACC_PEEK,     // read of a lower slice
    ACC_ADVANCE,  // read of the top slice
    ACC_CTLRD     // read of the pointer word
  } acc_e;

endpackage

// File: rtl/tblwin_decode.sv
module tblwin_decode
  import tblwin_pkg::*;
#(
  parameter int HA_W   = 6,
  parameter int BASE   = 19,
  parameter int NWORDS = 4,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic            wr,
  input  logic            rd,
  input  logic [HA_W-1:0] addr,
  output acc_e            acc,
  output logic [IDXW-1:0] word_idx,
  output logic            sel_ctl,
  output logic            sel_data
);

  logic [HA_W-1:0] off;
  logic            is_last;

  assign off      = addr - HA_W'(BASE);
  assign sel_ctl  = (off == '0);
  assign sel_data = (off != '0) && (off <= HA_W'(NWORDS));
  assign is_last  = (off == HA_W'(NWORDS));
  assign word_idx = IDXW'(off - HA_W'(1));

  always_comb begin
    acc = ACC_NONE;
    if (wr) begin
      if (sel_ctl)      acc = ACC_SET;
      else if (is_last) acc = ACC_COMMIT;
      else if (sel_data) acc = ACC_STAGE;
    end else if (rd) begin
      if (sel_ctl)      acc = ACC_CTLRD;
      else if (is_last) acc = ACC_ADVANCE;
      else if (sel_data) acc = ACC_PEEK;
    end
  end

endmodule

// File: rtl/tblwin_ram.sv
module tblwin_ram #(
  parameter int AW = 10,
  parameter int DW = 64,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end

endmodule

// File: rtl/tblwin_regs.sv
module tblwin_regs
  import tblwin_pkg::*;
#(
  parameter int AW       = 10,
  parameter int WORD_W   = 16,
  parameter int NWORDS   = 4,
  parameter int STEP_BIT = 15,
  localparam int IDXW    = $clog2(NWORDS),
  localparam int ENTRY_W = WORD_W * NWORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  acc_e               acc,
  input  logic [IDXW-1:0]    word_idx,
  input  logic               sel_ctl,
  input  logic               sel_data,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [ENTRY_W-1:0] ram_q,
  output logic               ram_en,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic [ENTRY_W-1:0] ram_wdata,
  output logic [WORD_W-1:0]  rdata,
  output logic               ev_set,
  output logic               ev_commit,
  output logic               ev_advance,
  output logic               ev_step,
  output logic               fetch_pend,
  output logic               rd_issue,
  output logic               ld_pend,
  output logic [AW-1:0]      cur_addr,
  output logic               step_en
);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [WORD_W-1:0] ctl_word(input logic [AW-1:0] a, input logic s);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[AW-1:0]   = a;
    w[STEP_BIT] = s;
    return w;
  endfunction

  logic [WORD_W-1:0]  wstage [NWORDS-1];
  logic [ENTRY_W-1:0] rstage;
  logic [WORD_W-1:0]  rword  [NWORDS];

  assign ev_set     = (acc == ACC_SET);
  assign ev_commit  = (acc == ACC_COMMIT);
  assign ev_advance = (acc == ACC_ADVANCE);
  assign ev_step    = (ev_commit || ev_advance) && step_en;
  assign rd_issue   = fetch_pend && !ev_commit;

  // pointer and post-increment switch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      step_en  <= 1'b0;
    end else if (ev_set) begin
      cur_addr <= wdata[AW-1:0];
      step_en  <= wdata[STEP_BIT];
    end else if (ev_step) begin
      cur_addr <= bump(cur_addr);
    end
  end

  // write staging slices
  for (genvar g = 0; g < NWORDS - 1; g++) begin : g_wstage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wstage[g] <= '0;
      else if (acc == ACC_STAGE && word_idx == IDXW'(g)) wstage[g] <= wdata;
    end
  end

  // fetch pipeline: request, memory read, load of read copies
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pend <= 1'b0;
      ld_pend    <= 1'b0;
      rstage     <= '0;
    end else begin
      fetch_pend <= ev_set || ev_commit || ev_advance;
      ld_pend    <= rd_issue;
      if (ld_pend) rstage <= ram_q;
    end
  end

  always_comb begin
    for (int i = 0; i < NWORDS - 1; i++) ram_wdata[i*WORD_W +: WORD_W] = wstage[i];
    ram_wdata[(NWORDS-1)*WORD_W +: WORD_W] = wdata;
  end

  assign ram_en   = ev_commit || rd_issue;
  assign ram_we   = ev_commit;
  assign ram_addr = cur_addr;

  for (genvar g = 0; g < NWORDS; g++) begin : g_rword
    assign rword[g] = rstage[g*WORD_W +: WORD_W];
  end

  always_comb begin
    if (sel_ctl)       rdata = ctl_word(cur_addr, step_en);
    else if (sel_data) rdata = rword[word_idx];
    else               rdata = '0;
  end

endmodule

// File: rtl/tblwin_top.sv
module tblwin_top
  import tblwin_pkg::*;
#(
  parameter int AW       = 10,
  parameter int WORD_W   = 16,
  parameter int NWORDS   = 4,
  parameter int HA_W     = 6,
  parameter int BASE     = 19,
  parameter int STEP_BIT = 15,
  localparam int IDXW    = $clog2(NWORDS),
  localparam int ENTRY_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [HA_W-1:0]   hst_addr,
  input  logic [WORD_W-1:0] hst_wdata,
  output logic [WORD_W-1:0] hst_rdata
);

  acc_e               acc;
  logic [IDXW-1:0]    word_idx;
  logic               sel_ctl, sel_data;
  logic               ram_en, ram_we;
  logic [AW-1:0]      ram_addr;
  logic [ENTRY_W-1:0] ram_wdata, ram_q;
  logic               ev_set, ev_commit, ev_advance, ev_step;
  logic               fetch_pend, rd_issue, ld_pend;
  logic [AW-1:0]      cur_addr;
  logic               step_en;

  tblwin_decode #(.HA_W(HA_W), .BASE(BASE), .NWORDS(NWORDS)) u_dec (
    .wr(hst_wr), .rd(hst_rd), .addr(hst_addr),
    .acc(acc), .word_idx(word_idx), .sel_ctl(sel_ctl), .sel_data(sel_data)
  );

  tblwin_regs #(.AW(AW), .WORD_W(WORD_W), .NWORDS(NWORDS), .STEP_BIT(STEP_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .word_idx(word_idx),
    .sel_ctl(sel_ctl), .sel_data(sel_data), .wdata(hst_wdata), .ram_q(ram_q),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .rdata(hst_rdata), .ev_set(ev_set), .ev_commit(ev_commit), .ev_advance(ev_advance),
    .ev_step(ev_step), .fetch_pend(fetch_pend), .rd_issue(rd_issue), .ld_pend(ld_pend),
    .cur_addr(cur_addr), .step_en(step_en)
  );

  tblwin_ram #(.AW(AW), .DW(ENTRY_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

endmodule

// File: rtl/tblwin_chk.sv
module tblwin_chk #(
  parameter int AW       = 10,
  parameter int WORD_W   = 16,
  parameter int HA_W     = 6,
  parameter int STEP_BIT = 15,
  parameter int ENTRY_W  = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hst_wr,
  input logic [WORD_W-1:0]  hst_wdata,
  input logic               sel_ctl,
  input logic               sel_data,
  input logic               ev_set,
  input logic               ev_commit,
  input logic               ev_step,
  input logic               ram_we,
  input logic [AW-1:0]      ram_addr,
  input logic [ENTRY_W-1:0] ram_wdata,
  input logic               ld_pend,
  input logic [AW-1:0]      cur_addr,
  input logic               step_en
);

  a_r3_set_loads_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set |=> (cur_addr == $past(hst_wdata[AW-1:0])) && (step_en == $past(hst_wdata[STEP_BIT])));

  a_r5_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> cur_addr == AW'($past(cur_addr) + AW'(1)));

  a_r6_pointer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_set && !ev_step) |=> $stable(cur_addr) && $stable(step_en));

  a_r4_commit_port: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> ram_we && (ram_addr == cur_addr)
                  && (ram_wdata[ENTRY_W-1 -: WORD_W] == hst_wdata));

  a_r11_commit_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> !ld_pend);

  a_r12_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && !sel_ctl && !sel_data) |=> $stable(cur_addr) && $stable(step_en));

endmodule

bind tblwin_top tblwin_chk #(
  .AW(AW), .WORD_W(WORD_W), .HA_W(HA_W), .STEP_BIT(STEP_BIT), .ENTRY_W(ENTRY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_wdata(hst_wdata),
  .sel_ctl(sel_ctl), .sel_data(sel_data), .ev_set(ev_set), .ev_commit(ev_commit),
  .ev_step(ev_step), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
  .ld_pend(ld_pend), .cur_addr(cur_addr), .step_en(step_en)
);

// File: tb/tblwin_top_test.sv
module tblwin_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0;
  logic        hst_rd = 1'b0;
  logic [5:0]  hst_addr = '0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tblwin_top uut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] mm [1024];
  bit          mv [1024];
  int          m_ptr;
  bit          m_step;
  logic [15:0] m_ws [3];
  logic [63:0] m_rs;
  bit          m_rsv;
  bit          m_pend, m_ld, m_qv;
  logic [63:0] m_q;

  initial for (int i = 0; i < 1024; i++) mv[i] = 1'b0;

  function automatic int offs(input logic [5:0] a);
    return int'(a) - 19;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_step = 0; m_rs = '0; m_rsv = 1; m_pend = 0; m_ld = 0;
      for (int i = 0; i < 3; i++) m_ws[i] = '0;
    end else begin
      int  o;
      bit  set, stg, com, adv, issue;
      o     = offs(hst_addr);
      set   = hst_wr && o == 0;
      stg   = hst_wr && o >= 1 && o <= 3;
      com   = hst_wr && o == 4;
      adv   = !hst_wr && hst_rd && o == 4;
      issue = m_pend && !com;
      if (m_ld) begin m_rs = m_q; m_rsv = m_qv; end
      if (issue) begin m_q = mm[m_ptr]; m_qv = mv[m_ptr]; end
      m_ld = issue;
      if (com) begin mm[m_ptr] = {hst_wdata, m_ws[2], m_ws[1], m_ws[0]}; mv[m_ptr] = 1; end
      if (stg) m_ws[o-1] = hst_wdata;
      if (set) begin m_ptr = int'(hst_wdata[9:0]); m_step = hst_wdata[15]; end
      else if ((com || adv) && m_step) m_ptr = (m_ptr + 1) % 1024;
      m_pend = set || com || adv;
    end
    #2;
    if (rst_n && !done) begin
      int o;
      logic [15:0] e;
      bit known;
      o = offs(hst_addr);
      known = 1;
      if (o == 0) e = {m_step, 5'b0, 10'(m_ptr)};
      else if (o >= 1 && o <= 4) begin e = m_rs[(o-1)*16 +: 16]; known = m_rsv; end
      else e = '0;
      if (known) begin
        checks++;
        if (hst_rdata !== e) begin
          fails++;
          $display("FAIL %s per-clock model addr=%h got=%h exp=%h",
                   (o == 0) ? "R2" : ((o >= 1 && o <= 4) ? "R9" : "R12"), hst_addr, hst_rdata, e);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_rd = 1'b0; hst_addr = a; hst_wdata = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      hst_wr = 1'b0; hst_rd = 1'b0;
    end
  endtask

  task automatic chk_rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    hst_wr = 1'b0; hst_rd = 1'b1; hst_addr = a;
    #1;
    checks++;
    if (hst_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, hst_rdata, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_rd(6'h13, 16'h0000, "R1");
    chk_rd(6'h14, 16'h0000, "R1");
    chk_rd(6'h16, 16'h0000, "R1");

    // R2 R3: pointer word format and load
    put(6'h13, 16'h8005); idle(3);
    chk_rd(6'h13, 16'h8005, "R2 R3");

    // R4 R5: stage out of order, commit, pointer advances
    put(6'h14, 16'h1111); put(6'h16, 16'h3333); put(6'h15, 16'h2222); put(6'h17, 16'h4444);
    idle(3);
    chk_rd(6'h13, 16'h8006, "R5");
    put(6'h15, 16'h6666); put(6'h14, 16'h5555); put(6'h16, 16'h7777); put(6'h17, 16'h8888);
    idle(3);
    chk_rd(6'h13, 16'h8007, "R5");

    // R7 R8 R9: read back entry 5, top read advances and fetches entry 6
    put(6'h13, 16'h8005); idle(3);
    chk_rd(6'h15, 16'h2222, "R7");
    chk_rd(6'h14, 16'h1111, "R7");
    chk_rd(6'h16, 16'h3333, "R7");
    chk_rd(6'h13, 16'h8005, "R7");
    chk_rd(6'h17, 16'h4444, "R7");
    idle(3);
    chk_rd(6'h13, 16'h8006, "R8");
    chk_rd(6'h14, 16'h5555, "R8 R9");
    chk_rd(6'h17, 16'h8888, "R8");

    // R6 R4: switch off, commit then read back, pointer held
    put(6'h13, 16'h0005);
    put(6'h14, 16'hAAAA); put(6'h15, 16'hBBBB); put(6'h16, 16'hCCCC); put(6'h17, 16'hDDDD);
    idle(3);
    chk_rd(6'h13, 16'h0005, "R6");
    chk_rd(6'h14, 16'hAAAA, "R4");
    chk_rd(6'h16, 16'hCCCC, "R4");
    chk_rd(6'h17, 16'hDDDD, "R4");
    idle(1);
    chk_rd(6'h13, 16'h0005, "R6");

    // R10: wrap at the top entry, then fill entry 0
    put(6'h13, 16'h83FF);
    put(6'h14, 16'h0101); put(6'h15, 16'h0202); put(6'h16, 16'h0303); put(6'h17, 16'h0404);
    idle(3);
    chk_rd(6'h13, 16'h8000, "R10");
    put(6'h14, 16'h0A00); put(6'h15, 16'h0A01); put(6'h16, 16'h0A02); put(6'h17, 16'h0A03);
    idle(3);
    chk_rd(6'h13, 16'h8001, "R10");

    // R11: back-to-back commits, second lands while the first fetch is due
    put(6'h13, 16'h83FE);
    put(6'h14, 16'hE0E0); put(6'h15, 16'hE1E1); put(6'h16, 16'hE2E2);
    put(6'h17, 16'h1111); put(6'h17, 16'h2222);
    idle(3);
    chk_rd(6'h13, 16'h8000, "R11");
    chk_rd(6'h14, 16'h0A00, "R11");
    chk_rd(6'h17, 16'h0A03, "R11");
    idle(3);
    put(6'h13, 16'h03FE); idle(3);
    chk_rd(6'h17, 16'h1111, "R11");
    chk_rd(6'h14, 16'hE0E0, "R11");
    put(6'h13, 16'h03FF); idle(3);
    chk_rd(6'h17, 16'h2222, "R11");
    chk_rd(6'h16, 16'hE2E2, "R11");

    // R12: outside the window
    chk_rd(6'h12, 16'h0000, "R12");
    chk_rd(6'h18, 16'h0000, "R12");
    chk_rd(6'h00, 16'h0000, "R12");
    put(6'h18, 16'hFFFF); put(6'h12, 16'h8123); idle(2);
    chk_rd(6'h13, 16'h03FF, "R12");
    chk_rd(6'h16, 16'hE2E2, "R12");

    idle(4);
    finish_run();
  end

endmodule